// File: doc/BRIEF.md
# MIR Transmit Framer with Zero-Bit Insertion

This block turns a stream of payload bytes into one medium-rate infrared frame on a single serial line. The host presents bytes on a valid/ready port and marks the final byte of the frame. The block adds everything else on its own. It sends a programmable run of opening flag octets, then the payload, then a 16-bit check sequence computed over the payload, then one closing flag. Inside the payload and check sequence it inserts a zero after any five ones in a row, so the flag pattern cannot appear there.

The line advances one bit on each clock cycle where `bit_en` is high. The host sets the line rate, for example 0.576 or 1.152 Mbit/s, through the rate of that strobe. Inside the frame the block holds one byte ahead of the bit in flight. `busy` tells the host when a frame is on the line. Between frames the line rests at the idle level, 1.

Top module: `mirtx_framer`

## Requirements
- R1: After reset, `busy` is 0, `tx_bit` is 1 and `in_ready` is 1.
- R2: `tx_bit` changes only on a clock edge where `bit_en` is high.
- R3: A frame starts on the first byte handshake while idle. It opens with N flag octets 0x7E, each sent least significant bit first. N is taken from `cfg_nflags` at that handshake, and values 0 and 1 give 2. Changes to `cfg_nflags` later in the frame have no effect on that frame.
- R4: Payload bytes follow the opening flags in the order they were accepted, each least significant bit first. The byte accepted with `in_last` high is the final one.
- R5: After the final byte the block sends a 16-bit check value, least significant bit first. It is the ones complement of a CRC. The CRC uses the reflected polynomial 0x8408 (x^16+x^12+x^5+1), starts at 0xFFFF and runs over the payload bits in line order.
- R6: In the payload and check fields, a 0 is inserted after every five consecutive 1 bits. The run count restarts after any 0, including an inserted one. A run of five that ends the check field is still followed by a 0 before the closing flag. Flag octets are never altered.
- R7: One closing flag 0x7E follows the check field. On the next strobe after the frame, the line returns to 1.
- R8: Once the first byte has been taken, `in_ready` stays low through the opening flags. After the byte marked last has been taken, it stays low until the frame ends. Exactly the bytes of the frame are accepted during it.
- R9: `busy` rises on the edge that accepts the first byte. It falls on the edge that emits the last bit of the closing flag. The frame then holds exactly 8·N + payload bits + 16 + inserted zeros + 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_nflags | input | CNT_W | Requested number of opening flags |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte ends the frame |
| bit_en | input | 1 | One pulse per line bit period |
| tx_bit | output | 1 | Serial line output |
| busy | output | 1 | Frame in progress |

## Verification
Assertions check several things on every cycle. The line holds between strobes. A strobe taken while a run of five ones is pending puts a 0 on the line. The ones counter never goes past five. `busy` rises only on an accepted byte and falls only on a strobe. The bench covers what depends on whole frames. It compares every line bit against a bitstream it builds on its own, across payload lengths, bit patterns that force stuffing, flag counts including the clamped ones, and two strobe rates. It also checks the check-field value, the handshake count and the late change of `cfg_nflags`.

// File: rtl/mirtx_pkg.sv
package mirtx_pkg;
   localparam int unsigned OCT_W = 8;
   localparam int unsigned FCS_W = 16;
   localparam logic [OCT_W-1:0] FLAG_OCTET = 8'h7E;

   typedef logic [OCT_W-1:0] octet_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_OPEN,
      PH_BODY,
      PH_FCS,
      PH_CLOSE
   } phase_e;
endpackage

// File: rtl/mirtx_crc16.sv
module mirtx_crc16 #(
   parameter logic [15:0] POLY = 16'h8408,
   parameter logic [15:0] INIT = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        adv,
   input  logic        bit_in,
   output logic [15:0] crc_nxt
);
   logic [15:0] crc_q;
   logic        fb;

   assign fb = crc_q[0] ^ bit_in;

   for (genvar i = 0; i < 15; i++) begin : g_tap
      assign crc_nxt[i] = crc_q[i+1] ^ (fb & POLY[i]);
   end
   assign crc_nxt[15] = fb & POLY[15];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= INIT;
      else if (clr)  crc_q <= INIT;
      else if (adv)  crc_q <= crc_nxt;
   end
endmodule

// File: rtl/mirtx_stuff_ctr.sv
module mirtx_stuff_ctr #(
   parameter int unsigned STUFF_RUN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic emit,
   input  logic count_en,
   input  logic bit_in,
   output logic stuff_due
);
   localparam int unsigned RUN_W = $clog2(STUFF_RUN + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_RUN);

   logic [RUN_W-1:0] ones_q;

   if (STUFF_RUN < 1 || STUFF_RUN > 7) begin : g_bad_run
      $error("mirtx_stuff_ctr: STUFF_RUN must be 1..7");
   end

   assign stuff_due = (ones_q == RUN_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ones_q <= '0;
      else if (clr)
         ones_q <= '0;
      else if (emit) begin
         if (stuff_due || !count_en || !bit_in) ones_q <= '0;
         else                                   ones_q <= ones_q + 1'b1;
      end
   end

   // R6: the run counter never passes the stuffing threshold
   assert_run_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= RUN_MAX);
endmodule

// File: rtl/mirtx_framer.sv
module mirtx_framer #(
   parameter int unsigned CNT_W     = 4,
   parameter int unsigned MIN_FLAGS = 2,
   parameter int unsigned STUFF_RUN = 5,
   parameter logic        IDLE_LVL  = 1'b1,
   parameter logic [15:0] CRC_POLY  = 16'h8408,
   parameter logic [15:0] CRC_INIT  = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_nflags,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   input  logic             bit_en,
   output logic             tx_bit,
   output logic             busy
);
   import mirtx_pkg::*;

   localparam int unsigned POS_W = $clog2(FCS_W);
   localparam logic [POS_W-1:0] OCT_END = POS_W'(OCT_W - 1);
   localparam logic [POS_W-1:0] FCS_END = POS_W'(FCS_W - 1);
   localparam logic [CNT_W-1:0] MIN_N   = CNT_W'(MIN_FLAGS);

   if (MIN_FLAGS < 2 || MIN_FLAGS >= (1 << CNT_W)) begin : g_bad_min
      $error("mirtx_framer: MIN_FLAGS must be at least 2 and fit CNT_W");
   end
   if (OCT_W != 8 || FCS_W != 16) begin : g_bad_width
      $error("mirtx_framer: octet and check widths are fixed at 8 and 16");
   end

   phase_e            ph_q;
   logic [FCS_W-1:0]  sh_q;
   logic [POS_W-1:0]  pos_q;
   logic [CNT_W-1:0]  fcnt_q, nfl_q, nfl_sel;
   octet_t            hold_q;
   logic              hold_v_q, hold_last_q, cur_last_q, last_taken_q, tx_q;

   logic              fire, emit, stuff_due, shift_en, cur_bit, unit_end;
   logic              body_or_fcs, start_frame, byte_avail;
   logic [15:0]       crc_nxt;

   assign nfl_sel     = (cfg_nflags < MIN_N) ? MIN_N : cfg_nflags;
   assign in_ready    = (ph_q == PH_IDLE) ||
                        (ph_q == PH_BODY && !hold_v_q && !last_taken_q);
   assign fire        = in_valid && in_ready;
   assign start_frame = fire && (ph_q == PH_IDLE);
   assign emit        = bit_en && (ph_q != PH_IDLE);
   assign shift_en    = emit && !stuff_due;
   assign cur_bit     = sh_q[0];
   assign body_or_fcs = (ph_q == PH_BODY) || (ph_q == PH_FCS);
   assign unit_end    = (pos_q == ((ph_q == PH_FCS) ? FCS_END : OCT_END));
   assign byte_avail  = hold_v_q || fire;
   assign busy        = (ph_q != PH_IDLE);
   assign tx_bit      = tx_q;

   mirtx_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_frame),
      .adv     (shift_en && ph_q == PH_BODY),
      .bit_in  (cur_bit),
      .crc_nxt (crc_nxt)
   );

   mirtx_stuff_ctr #(.STUFF_RUN(STUFF_RUN)) u_stuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start_frame),
      .emit      (emit),
      .count_en  (body_or_fcs),
      .bit_in    (cur_bit),
      .stuff_due (stuff_due)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q         <= PH_IDLE;
         sh_q         <= '0;
         pos_q        <= '0;
         fcnt_q       <= '0;
         nfl_q        <= MIN_N;
         hold_q       <= '0;
         hold_v_q     <= 1'b0;
         hold_last_q  <= 1'b0;
         cur_last_q   <= 1'b0;
         last_taken_q <= 1'b0;
         tx_q         <= IDLE_LVL;
      end else if (start_frame) begin
         ph_q         <= PH_OPEN;
         sh_q         <= {8'h00, FLAG_OCTET};
         pos_q        <= '0;
         fcnt_q       <= '0;
         nfl_q        <= nfl_sel;
         hold_q       <= in_data;
         hold_v_q     <= 1'b1;
         hold_last_q  <= in_last;
         last_taken_q <= in_last;
         if (bit_en) tx_q <= IDLE_LVL;
      end else begin
         if (fire) begin
            hold_q      <= in_data;
            hold_last_q <= in_last;
            hold_v_q    <= 1'b1;
            if (in_last) last_taken_q <= 1'b1;
         end
         if (bit_en && ph_q == PH_IDLE) tx_q <= IDLE_LVL;
         if (emit) begin
            if (stuff_due) begin
               tx_q <= 1'b0;
            end else begin
               tx_q  <= cur_bit;
               sh_q  <= sh_q >> 1;
               pos_q <= pos_q + 1'b1;
               if (unit_end) begin
                  pos_q <= '0;
                  unique case (ph_q)
                     PH_OPEN: begin
                        if (fcnt_q == nfl_q - 1'b1) begin
                           ph_q       <= PH_BODY;
                           sh_q       <= {8'h00, hold_q};
                           cur_last_q <= hold_last_q;
                           hold_v_q   <= 1'b0;
                        end else begin
                           fcnt_q <= fcnt_q + 1'b1;
                           sh_q   <= {8'h00, FLAG_OCTET};
                        end
                     end
                     PH_BODY: begin
                        if (cur_last_q || !byte_avail) begin
                           ph_q <= PH_FCS;
                           sh_q <= ~crc_nxt;
                        end else if (hold_v_q) begin
                           sh_q       <= {8'h00, hold_q};
                           cur_last_q <= hold_last_q;
                           hold_v_q   <= 1'b0;
                        end else begin
                           sh_q       <= {8'h00, in_data};
                           cur_last_q <= in_last;
                           hold_v_q   <= 1'b0;
                        end
                     end
                     PH_FCS: begin
                        ph_q <= PH_CLOSE;
                        sh_q <= {8'h00, FLAG_OCTET};
                     end
                     PH_CLOSE: ph_q <= PH_IDLE;
                     default:  ph_q <= PH_IDLE;
                  endcase
               end
            end
         end
      end
   end

   // R2: the line holds its value between strobes
   assert_line_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_bit));

   // R6: a strobe taken with a full run of ones drives an inserted zero
   assert_stuff_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && busy && stuff_due) |=> !tx_bit);

   // R9: a frame begins only on an accepted byte
   assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(in_valid && in_ready));

   // R9: a frame ends only on a strobe
   assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(bit_en));
endmodule

// File: tb/mirtx_framer_tb.sv
module mirtx_framer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cfg_nflags = 4'd2;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic       in_last = 1'b0;
   logic       bit_en = 1'b0;
   logic       tx_bit;
   logic       busy;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   bit exp_b [0:4095];
   bit got_b [0:4095];
   int exp_n;
   int ones_m;

   always #5 clk = ~clk;

   mirtx_framer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_nflags (cfg_nflags),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .in_last    (in_last),
      .bit_en     (bit_en),
      .tx_bit     (tx_bit),
      .busy       (busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic logic [7:0] pay_byte(input int pat, input int len, input int i);
      case (pat)
         0: return 8'hFF;
         1: return 8'h00;
         2: return 8'((i * 37 + len * 11 + 5) & 255);
         default: return (i % 2 == 1) ? 8'h3F : 8'h7E;
      endcase
   endfunction

   task automatic push_raw(input bit b);
      exp_b[exp_n] = b;
      exp_n++;
   endtask

   task automatic push_stuffed(input bit b);
      push_raw(b);
      if (b) ones_m++; else ones_m = 0;
      if (ones_m == 5) begin
         push_raw(1'b0);
         ones_m = 0;
      end
   endtask

   task automatic build_expected(input int len, input int pat, input int nfl);
      logic [15:0] crc;
      logic [7:0]  bv;
      bit          fb;
      exp_n  = 0;
      ones_m = 0;
      crc    = 16'hFFFF;
      for (int f = 0; f < nfl; f++)
         for (int k = 0; k < 8; k++) push_raw(((8'h7E >> k) & 8'h01) != 0);
      for (int i = 0; i < len; i++) begin
         bv = pay_byte(pat, len, i);
         for (int k = 0; k < 8; k++) begin
            fb  = crc[0] ^ bv[k];
            crc = crc >> 1;
            if (fb) crc = crc ^ 16'h8408;
            push_stuffed(bv[k]);
         end
      end
      crc = ~crc;
      for (int k = 0; k < 16; k++) push_stuffed(crc[k]);
      for (int k = 0; k < 8; k++) push_raw(((8'h7E >> k) & 8'h01) != 0);
   endtask

   task automatic run_frame(input int len, input int pat, input int cfg,
                            input int cfg_after, input int period);
      int  nfl, idx, gotn, fires, cyc, guard, viol_r, viol_s, mism, first_bad;
      bit  started, lastfired, fire_now, cap_now, be_now, txprev, done;
      nfl = (cfg < 2) ? 2 : cfg;
      build_expected(len, pat, nfl);
      idx = 0; gotn = 0; fires = 0; cyc = 0; guard = 0;
      viol_r = 0; viol_s = 0; started = 0; lastfired = 0; done = 0;
      @(negedge clk);
      cfg_nflags = 4'(cfg);
      in_valid   = 1'b1;
      in_data    = pay_byte(pat, len, 0);
      in_last    = (len == 1);
      bit_en     = 1'b0;
      txprev     = tx_bit;
      while (!done && guard < 20000) begin
         guard++;
         fire_now = in_valid && in_ready;
         cap_now  = bit_en && busy;
         be_now   = bit_en;
         if (started && in_ready && (gotn < nfl * 8 || lastfired)) viol_r++;
         @(negedge clk);
         if (cap_now) begin
            if (gotn < 4096) got_b[gotn] = tx_bit;
            gotn++;
         end
         if (!be_now && tx_bit != txprev) viol_s++;
         txprev = tx_bit;
         if (fire_now) begin
            fires++;
            if (!started) begin
               started = 1'b1;
               check(busy == 1'b1, "R9 busy after first byte", int'(busy), 1);
               cfg_nflags = 4'(cfg_after);
            end
            if (in_last) lastfired = 1'b1;
            idx++;
            if (idx < len) begin
               in_data = pay_byte(pat, len, idx);
               in_last = (idx == len - 1);
            end else begin
               in_valid = 1'b0;
               in_last  = 1'b0;
            end
         end
         if (started && !busy) done = 1'b1;
         cyc++;
         bit_en = ((cyc % period) == 0);
      end
      check(done, "R9 frame completes", int'(done), 1);
      check(gotn == exp_n, "R9 frame bit count", gotn, exp_n);
      mism = 0; first_bad = -1;
      for (int b = 0; b < exp_n && b < gotn && b < 4096; b++)
         if (got_b[b] != exp_b[b]) begin
            mism++;
            if (first_bad < 0) first_bad = b;
         end
      if (mism != 0)
         $display("  first mismatch at bit %0d (len=%0d pat=%0d nfl=%0d)",
                  first_bad, len, pat, nfl);
      check(mism == 0, "R3/R4/R5/R6/R7 line bits mismatches", mism, 0);
      check(fires == len, "R8 bytes accepted", fires, len);
      check(viol_r == 0, "R8 ready high during flags or after last", viol_r, 0);
      check(viol_s == 0, "R2 line changed without strobe", viol_s, 0);
      // R7: next strobe after the frame puts the idle level on the line
      @(negedge clk);
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      check(tx_bit == 1'b1, "R7 idle level after frame", int'(tx_bit), 1);
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      check(tx_bit == 1'b1, "R1 line after reset", int'(tx_bit), 1);
      check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
      for (int per = 1; per <= 3; per += 2)
         for (int pat = 0; pat < 4; pat++)
            for (int len = 1; len <= 6; len++)
               run_frame(len, pat, (len + pat) % 6, (len + pat) % 6, per);
      // R3: a late change of the flag count leaves the running frame alone
      run_frame(3, 2, 3, 15, 2);
      run_frame(2, 0, 15, 15, 1);
      run_frame(4, 3, 1, 0, 2);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule